// File: doc/BRIEF.md
# SPI Master with Selectable Clock Mode

This block drives a byte-wide SPI link as bus master. Each transfer moves eight bits out on the serial data output and eight bits in from the serial data input. The most significant bit goes first in both directions. Clock polarity, clock phase and a two-bit rate field are plain control inputs. Together they cover all four SPI clock modes. The serial clock half-period is 2^(N+1) system clocks, where N is the rate field. Another plain input, an index, picks one line of an active-low slave-select vector. That line is driven low for the whole byte.

The byte to send enters on a valid/ready stream input. A byte is taken in any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while a transfer runs and while the external fault input is asserted, so the producer simply holds its byte until it is taken. The received byte leaves on `rx_data` with a one-cycle `rx_valid` strobe. That output has no back-pressure: the byte stays on `rx_data` until the next transfer ends. `busy` is high from the accepting cycle until the cycle in which the received byte is loaded.

`ss_in_n` is an active-low input that another master can pull low at any time. It is synchronized inside the block. Once it arrives, any running transfer is abandoned, the bus lines return to idle, and a sticky `mode_fault` flag is set. The flag stays set until the next accepted transfer.

Top module: `spi_mode_master`

## Requirements
- R1: After reset: `ss_n` is all ones, `busy` = 0, `mode_fault` = 0, `rx_valid` = 0, `rx_data` = 0 and `tx_ready` = 1.
- R2: While no transfer is running, `sck` follows `cpol`, one cycle later.
- R3: A byte is accepted in a cycle where `tx_valid` and `tx_ready` are both high. From the next cycle on, `busy` = 1 and `tx_ready` = 0.
- R4: During a transfer, only the `ss_n` bit selected by `ss_sel` is 0 and that vector does not change. At all other times `ss_n` is all ones.
- R5: The transmit byte leaves on `mosi` MSB first. With `cpha` = 0, bit 7 is on `mosi` from the cycle that `ss_n` asserts, before the first `sck` edge. With `cpha` = 1, bit 7 is launched on the first `sck` edge.
- R6: `miso` is sampled on the rising `sck` edge when `cpha` equals `cpol`, and on the falling edge otherwise. `mosi` changes on the opposite edge. The eight samples, first sample as bit 7, form the received byte.
- R7: `busy` stays high for exactly 17·2^(N+1) cycles, where N is the rate field `div_sel`. That is sixteen `sck` edges plus one closing half-period.
- R8: The received byte appears on `rx_data`, with `rx_valid` high for exactly one cycle, in the same cycle that `busy` drops.
- R9: `ss_in_n` held low for three clock edges during a transfer ends it. Then `busy` = 0, `ss_n` is all ones, `sck` is at the idle polarity, `mode_fault` = 1, and no `rx_valid` pulse is produced.
- R10: `tx_ready` stays 0 while the synchronized `ss_in_n` is low. `mode_fault` stays set until the next accepted transfer, which clears it.
- R11: Mode, rate and select are captured when a byte is accepted. Changing `cpol`, `cpha`, `div_sel` or `ss_sel` during a transfer does not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | 0: data valid before first edge; 1: first edge launches data |
| div_sel | input | DIV_W | Rate field N; half-period is 2^(N+1) clocks |
| ss_sel | input | SEL_W | Index of the slave-select line to drive |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block can take a byte |
| tx_data | input | DW | Byte to transmit |
| rx_data | output | DW | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when rx_data is updated |
| busy | output | 1 | Transfer in progress |
| mode_fault | output | 1 | Sticky flag: ss_in_n asserted |
| ss_in_n | input | 1 | Asynchronous active-low bus-taken input |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
The bench builds the block with its default parameters. That gives eight-bit transfers, four slave-select lines and a two-bit rate field, so every divide value from 2 to 16 clocks per half-period can be reached. Together with all four polarity/phase settings, this covers each capture-edge rule at each rate. The bench also selects both the lowest and the highest select index, which exercises the ends of the decode. A bench-side slave model, driven only by `sck`, `mosi` and `ss_n`, supplies the expected serial data and shows whether the launch and capture edges are placed correctly.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [1:0] div;
  } spim_mode_t;
endpackage

// File: rtl/spim_sync2.sv
module spim_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1, s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end
  assign q = s2;
endmodule

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] cnt;
  logic [DIV_W:0]   shamt;
  logic [CNT_W:0]   lim_m1;

  assign shamt  = {1'b0, div_sel} + (DIV_W+1)'(1);
  assign lim_m1 = ((CNT_W+1)'(1) << shamt) - (CNT_W+1)'(1);
  assign tick   = run && ({1'b0, cnt} == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_cpha,
  input  logic [DW-1:0] ld_byte,
  input  logic          launch,
  input  logic          capture,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_byte
);
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic          mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      rx_sh <= '0;
      if (ld_cpha) begin
        tx_sh <= ld_byte;
      end else begin
        mosi_q <= ld_byte[DW-1];
        tx_sh  <= ld_byte << 1;
      end
    end else begin
      if (launch) begin
        mosi_q <= tx_sh[DW-1];
        tx_sh  <= tx_sh << 1;
      end
      if (capture) rx_sh <= {rx_sh[DW-2:0], miso};
    end
  end

  assign mosi    = mosi_q;
  assign rx_byte = rx_sh;
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master #(
  parameter int DW    = 8,
  parameter int NSS   = 4,
  parameter int DIV_W = 2,
  parameter int SEL_W = (NSS > 1) ? $clog2(NSS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [SEL_W-1:0] ss_sel,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DW-1:0]    tx_data,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic             busy,
  output logic             mode_fault,
  input  logic             ss_in_n,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NSS-1:0]   ss_n
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES + 1);

  logic             busy_q, sck_q, fault_q, rxv_q;
  logic             cpol_l, cpha_l;
  logic [DIV_W-1:0] div_l;
  logic [NSS-1:0]   ss_q, ss_dec;
  logic [EW-1:0]    ecnt;
  logic [DW-1:0]    rx_q, rx_byte;
  logic             ss_in_s, tick, accept, abort, edge_t, fin;
  logic             lead, capture, launch;

  spim_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ss_in_n), .q(ss_in_s)
  );

  spim_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .div_sel(div_l), .tick(tick)
  );

  assign tx_ready = !busy_q && ss_in_s;
  assign accept   = tx_valid && tx_ready;
  assign abort    = busy_q && !ss_in_s;
  assign edge_t   = tick && (ecnt < EW'(EDGES));
  assign fin      = tick && (ecnt == EW'(EDGES));
  assign lead     = ~ecnt[0];
  assign capture  = edge_t && (lead == !cpha_l);
  assign launch   = edge_t && !capture;

  spim_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_cpha(cpha), .ld_byte(tx_data),
    .launch(launch && !abort), .capture(capture && !abort), .miso(miso),
    .mosi(mosi), .rx_byte(rx_byte)
  );

  for (genvar i = 0; i < NSS; i++) begin : g_dec
    assign ss_dec[i] = (ss_sel != SEL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      fault_q <= 1'b0;
      rxv_q   <= 1'b0;
      cpol_l  <= 1'b0;
      cpha_l  <= 1'b0;
      div_l   <= '0;
      ss_q    <= '1;
      ecnt    <= '0;
      rx_q    <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (abort) begin
        busy_q  <= 1'b0;
        sck_q   <= cpol_l;
        ss_q    <= '1;
        fault_q <= 1'b1;
      end else if (accept) begin
        busy_q  <= 1'b1;
        cpol_l  <= cpol;
        cpha_l  <= cpha;
        div_l   <= div_sel;
        ss_q    <= ss_dec;
        ecnt    <= '0;
        fault_q <= 1'b0;
        sck_q   <= cpol;
      end else if (busy_q) begin
        if (edge_t) begin
          sck_q <= ~sck_q;
          ecnt  <= ecnt + 1'b1;
        end
        if (fin) begin
          busy_q <= 1'b0;
          ss_q   <= '1;
          rx_q   <= rx_byte;
          rxv_q  <= 1'b1;
          sck_q  <= cpol_l;
        end
      end else begin
        sck_q <= cpol;
      end
    end
  end

  assign busy       = busy_q;
  assign sck        = sck_q;
  assign ss_n       = ss_q;
  assign rx_data    = rx_q;
  assign rx_valid   = rxv_q;
  assign mode_fault = fault_q;
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int NSS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpol,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic           busy,
  input logic           rx_valid,
  input logic           mode_fault,
  input logic           sck,
  input logic [NSS-1:0] ss_n
);
  // R2
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol) && $past(rst_n)) |-> sck == cpol);
  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && !tx_ready));
  // R4
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ss_n) <= 1);
  // R4
  select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ss_n));
  // R4
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ss_n == {NSS{1'b1}}));
  // R8
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($fell(busy) && !mode_fault));
  // R9
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_fault) |-> (!busy && !rx_valid));
endmodule

bind spi_mode_master spim_chk #(.NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .busy(busy), .rx_valid(rx_valid),
  .mode_fault(mode_fault), .sck(sck), .ss_n(ss_n)
);

// File: tb/spi_mode_master_bench.sv
`timescale 1ns/1ps
module spi_mode_master_bench;
  localparam int DW = 8, NSS = 4, DIV_W = 2, SEL_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 0, cpha = 0, tx_valid = 0, ss_in_n = 1, miso = 0;
  logic [DIV_W-1:0] div_sel = 0;
  logic [SEL_W-1:0] ss_sel = 0;
  logic [DW-1:0] tx_data = 0;
  logic tx_ready, rx_valid, busy, mode_fault, sck, mosi;
  logic [DW-1:0] rx_data;
  logic [NSS-1:0] ss_n;

  int checks = 0, fails = 0;

  // bench-side slave model
  logic          s_cpol = 0, s_cpha = 0;
  logic [DW-1:0] s_tx = 0, s_rx = 0;
  int            s_idx = 0;

  always #10 clk = ~clk;

  spi_mode_master u_spi_mode_master (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .div_sel(div_sel),
    .ss_sel(ss_sel), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .mode_fault(mode_fault),
    .ss_in_n(ss_in_n), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always @(sck) begin
    if (ss_n != {NSS{1'b1}}) begin
      if (sck == (s_cpha == s_cpol)) begin
        s_rx = {s_rx[DW-2:0], mosi};
      end else if (s_idx >= 0) begin
        miso  = s_tx[s_idx];
        s_idx = s_idx - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic pol, input logic pha, input int dv, input int sel,
                          input logic [DW-1:0] mb, input logic [DW-1:0] sb, input bit perturb);
    int cnt, half, rxv;
    half = 1 << (dv + 1);
    @(negedge clk);
    cpol = pol; cpha = pha; div_sel = DIV_W'(dv); ss_sel = SEL_W'(sel);
    repeat (2) @(negedge clk);
    chk(sck == pol, "R2 idle sck", sck, pol);
    s_cpol = pol; s_cpha = pha; s_tx = sb; s_rx = 0;
    if (!pha) begin miso = sb[DW-1]; s_idx = DW-2; end
    else s_idx = DW-1;
    tx_valid = 1; tx_data = mb;
    @(negedge clk);
    tx_valid = 0;
    chk(busy && !tx_ready, "R3 accept", {busy, tx_ready}, 2);
    chk(ss_n == ~(NSS'(1) << sel), "R4 select", ss_n, ~(NSS'(1) << sel));
    chk(mode_fault == 0, "R10 fault cleared on accept", mode_fault, 0);
    if (!pha) chk(mosi == mb[DW-1] && sck == pol, "R5 first bit before edge", mosi, mb[DW-1]);
    cnt = 1; rxv = 0;
    while (busy && cnt < 1000) begin
      if (perturb && cnt == 5) begin
        cpol = ~pol; cpha = ~pha; div_sel = DIV_W'(3 - dv); ss_sel = SEL_W'(sel ^ 1);
      end
      rxv += int'(rx_valid);
      @(negedge clk);
      if (busy) cnt++;
    end
    rxv += int'(rx_valid);
    chk(cnt == 17 * half, perturb ? "R11 latched rate" : "R7 duration", cnt, 17 * half);
    chk(rx_valid == 1 && rxv == 1, "R8 rx strobe with busy drop", rxv, 1);
    chk(rx_data == sb, "R6 received byte", rx_data, sb);
    chk(s_rx == mb, "R5 transmitted byte", s_rx, mb);
    chk(ss_n == {NSS{1'b1}}, "R4 release", ss_n, {NSS{1'b1}});
    chk(sck == pol, "R2 sck back idle", sck, pol);
    @(negedge clk);
    chk(rx_valid == 0, "R8 single strobe", rx_valid, 0);
    cpol = pol; cpha = pha; div_sel = DIV_W'(dv); ss_sel = SEL_W'(sel);
  endtask

  task automatic t_reset();
    chk(ss_n == {NSS{1'b1}} && !busy && !mode_fault && !rx_valid && rx_data == 0 && tx_ready,
        "R1 reset state", {ss_n, busy, mode_fault, rx_valid, tx_ready}, {4'hF, 4'b0001});
  endtask

  task automatic t_modes();
    logic [DW-1:0] a, b;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 4; d++) begin
        a = DW'(8'hA5 ^ (m * 16 + d * 7));
        b = DW'(8'h3C + m * 29 + d);
        run_xfer(m[1], m[0], d, (m + d) % NSS, a, b, 0);
      end
    end
    run_xfer(0, 1, 0, NSS-1, 8'h80, 8'h01, 0);
    run_xfer(1, 0, 1, 0, 8'hFF, 8'h00, 0);
  endtask

  task automatic t_latch();
    run_xfer(1, 1, 0, 2, 8'h69, 8'h96, 1);
  endtask

  task automatic t_abort();
    int rxv;
    @(negedge clk);
    cpol = 1; cpha = 0; div_sel = 1; ss_sel = 1;
    s_cpol = 1; s_cpha = 0; s_tx = 8'h55; s_rx = 0; miso = 0; s_idx = DW-2;
    repeat (2) @(negedge clk);
    tx_valid = 1; tx_data = 8'hC3;
    @(negedge clk);
    tx_valid = 0;
    repeat (10) @(negedge clk);
    ss_in_n = 0;
    rxv = 0;
    repeat (3) begin @(negedge clk); rxv += int'(rx_valid); end
    chk(!busy && ss_n == {NSS{1'b1}}, "R9 abort releases", {busy, ss_n}, {1'b0, 4'hF});
    chk(mode_fault == 1, "R9 fault set", mode_fault, 1);
    chk(sck == 1, "R9 sck idle", sck, 1);
    chk(rxv == 0, "R9 no rx strobe", rxv, 0);
    chk(tx_ready == 0, "R10 not ready while fault", tx_ready, 0);
    tx_valid = 1;
    @(negedge clk);
    chk(!busy, "R10 offer ignored during fault", busy, 0);
    tx_valid = 0;
    ss_in_n = 1;
    repeat (3) @(negedge clk);
    chk(tx_ready && mode_fault, "R10 ready again, fault sticky", {tx_ready, mode_fault}, 3);
    run_xfer(0, 0, 0, 3, 8'h5A, 8'hE7, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_modes();
    t_latch();
    t_abort();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule